// File: doc/BRIEF.md
# NAND Asynchronous Page-Read Sequencer

This block is the host side of an asynchronous NAND link. It drives one target over a shared 8-bit bus, using chip enable, command and address latch strobes, and active-low write and read enables. One request moves one page region to the rest of the chip. A request carries a row address, a start column and a byte count. The sequencer writes the read opcode, five address bytes and the confirm opcode. It then waits out the array-read busy time and returns the bytes on a valid/ready stream.

Readiness is found in one of two ways, picked per request. The first is the active-low ready/busy pin, which passes through a synchroniser and a settle window. The second is status polling: the sequencer writes the status opcode and reads status bytes until the ready bit is set, then writes the read opcode again so the target sends data instead of status. A poll budget ends the request with an error flag if the target never becomes ready. While bytes are streaming, a column-change request can be accepted together with any byte except the last. The sequencer then writes the column-change opcode, two column bytes and the change-confirm opcode, and streaming resumes at the new column.

Top module: `nand_page_reader`

## Requirements
- R1: While reset is asserted and after it is released with no request: `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_dq_oe`, `out_valid` and `timeout_err` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only while no request is active. The clock after a handshake on `req_valid`/`req_ready`, `nand_ce_n` is 0 and `req_ready` is 0. Chip enable stays low until the last byte is accepted or the poll budget runs out.
- R3: A request writes, in order: command 00h, the address bytes column[7:0], column[15:8], row[7:0], row[15:8] and row[23:16], then command 30h. Commands are written with `nand_cle`=1, `nand_ale`=0. Address bytes are written with `nand_ale`=1, `nand_cle`=0.
- R4: Each write cycle holds `nand_we_n` low for WE_LOW clocks and then high for WE_HIGH clocks. The latch strobes and the bus data stay steady while `nand_we_n` is low. `nand_we_n` and `nand_re_n` are never low together. While `nand_ce_n` is 1, both enables are high.
- R5: In pin mode (`req_poll`=0), no read cycle starts until at least RB_SETTLE clocks after the confirm command and `nand_rb_n` has been seen high through a two-stage synchroniser.
- R6: In poll mode (`req_poll`=1), the sequencer writes command 70h right after 30h. It then reads status bytes, with POLL_GAP idle clocks between reads, until bit 6 of a status byte is 1. It then writes command 00h before the first data read.
- R7: If POLL_MAX status reads in a row all show bit 6 at 0, `timeout_err` goes to 1, no data is delivered, and the block returns to idle. `timeout_err` clears when the next request is accepted.
- R8: A request with `req_len`=L delivers L+1 bytes in order, taken from consecutive columns starting at `req_col`. `out_last` is 1 on the final byte only. Each byte comes from one read-enable low pulse of RE_LOW clocks.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` holds steady and no read cycle runs (`nand_re_n`=1).
- R10: A column change offered on `chg_valid` with `chg_col` is taken when `chg_ready`=1. After the byte that was accepted in the same clock, the sequencer writes 05h, `chg_col[7:0]`, `chg_col[15:8]` and E0h. The following bytes come from `chg_col` onward, and the total byte count does not change.
- R11: `chg_ready` is 1 only while a non-last byte is offered and `out_ready`=1. A column change offered while idle or alongside the last byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Page-read request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_row | input | ROW_W | Row (page) address |
| req_col | input | COL_W | Start column |
| req_len | input | LEN_W | Byte count minus one |
| req_poll | input | 1 | 1: status polling, 0: ready/busy pin |
| chg_valid | input | 1 | Column change offered |
| chg_ready | output | 1 | Column change taken |
| chg_col | input | COL_W | New column |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read byte |
| out_last | output | 1 | Final byte of the request |
| timeout_err | output | 1 | Poll budget exhausted |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus value driven to the target |
| nand_dq_oe | output | 1 | Bus driver enable |
| nand_dq_i | input | 8 | Bus value from the target |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The assertions check the bus rules on every clock: the two enables never low together, exclusive latch strobes, steady strobes and data through a write pulse, idle enables while deselected, the settle window after the confirm, output hold under back-pressure, and the gating of column changes. The order of opcodes and address bytes, the exact pulse widths, the returned data across columns, the re-issue of the read opcode after polling, and the timeout can only be shown by the bench scenarios, which run a behavioural target that logs every latched cycle.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_READ} cyc_kind_e;

  localparam logic [7:0] OP_PAGE_RD   = 8'h00;
  localparam logic [7:0] OP_PAGE_GO   = 8'h30;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_COL_SEL   = 8'h05;
  localparam logic [7:0] OP_COL_GO    = 8'hE0;
  localparam int         STAT_RDY_BIT = 6;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_rd_pkg::*;
#(
  parameter int WE_LOW  = 2,
  parameter int WE_HIGH = 2,
  parameter int RE_LOW  = 3,
  parameter int RE_HIGH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  cyc_kind_e  kind,
  input  logic [7:0] wdata,
  input  logic [7:0] dq_i,
  output logic       idle,
  output logic       done,
  output logic [7:0] rdata,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_o,
  output logic       dq_oe
);
  localparam int MAX_W1 = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int MAX_W2 = (RE_LOW > RE_HIGH) ? RE_LOW : RE_HIGH;
  localparam int MAX_W  = (MAX_W1 > MAX_W2) ? MAX_W1 : MAX_W2;
  localparam int CW     = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  phase_e          ph_q, ph_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  cyc_kind_e       kind_q, kind_n;
  logic [7:0]      data_q, data_n;
  logic [7:0]      rd_q, rd_n;
  logic            is_rd;

  assign is_rd = (kind_q == CYC_READ);

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    kind_n = kind_q;
    data_n = data_q;
    rd_n   = rd_q;
    done   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_n   = PH_LOW;
          kind_n = kind;
          data_n = wdata;
          cnt_n  = (kind == CYC_READ) ? CW'(RE_LOW - 1) : CW'(WE_LOW - 1);
        end
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          ph_n  = PH_HIGH;
          cnt_n = is_rd ? CW'(RE_HIGH - 1) : CW'(WE_HIGH - 1);
          if (is_rd) rd_n = dq_i;
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
      PH_HIGH: begin
        if (cnt_q == '0) begin
          ph_n = PH_IDLE;
          done = 1'b1;
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= CYC_CMD;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      kind_q <= kind_n;
      data_q <= data_n;
      rd_q   <= rd_n;
    end
  end

  assign idle  = (ph_q == PH_IDLE);
  assign rdata = rd_q;
  assign we_n  = !((ph_q == PH_LOW) && !is_rd);
  assign re_n  = !((ph_q == PH_LOW) && is_rd);
  assign cle   = (ph_q != PH_IDLE) && (kind_q == CYC_CMD);
  assign ale   = (ph_q != PH_IDLE) && (kind_q == CYC_ADDR);
  assign dq_oe = (ph_q != PH_IDLE) && !is_rd;
  assign dq_o  = data_q;

  // R4
  enables_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R4
  strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R4
  we_pulse_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable({cle, ale, dq_o}));
endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
  parameter int RB_SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic rb_n,
  output logic ready
);
  localparam int SW = $clog2(RB_SETTLE + 1);

  logic [1:0]    sync_q;
  logic [SW-1:0] wait_q, wait_n;

  always_comb begin
    wait_n = wait_q;
    if (arm)              wait_n = SW'(RB_SETTLE);
    else if (wait_q != '0) wait_n = wait_q - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      wait_q <= '0;
    end else begin
      sync_q <= {sync_q[0], rb_n};
      wait_q <= wait_n;
    end
  end

  assign ready = (wait_q == '0) && sync_q[1];

  // R5
  settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !ready);
endmodule

// File: rtl/nand_addr_pick.sv
module nand_addr_pick #(
  parameter int COL_W = 16,
  parameter int ROW_W = 24
) (
  input  logic [$clog2((COL_W+ROW_W)/8)-1:0] idx,
  input  logic [COL_W-1:0]                   col,
  input  logic [ROW_W-1:0]                   row,
  output logic [7:0]                         sel_byte
);
  localparam int NB = (COL_W + ROW_W) / 8;

  logic [COL_W+ROW_W-1:0] flat;
  logic [7:0]             lanes [NB];

  assign flat = {row, col};

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = flat[g*8 +: 8];
  end

  assign sel_byte = lanes[idx];
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int COL_W     = 16,
  parameter int ROW_W     = 24,
  parameter int LEN_W     = 16,
  parameter int WE_LOW    = 2,
  parameter int WE_HIGH   = 2,
  parameter int RE_LOW    = 3,
  parameter int RE_HIGH   = 2,
  parameter int RB_SETTLE = 4,
  parameter int POLL_MAX  = 32,
  parameter int POLL_GAP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_poll,
  input  logic             chg_valid,
  output logic             chg_ready,
  input  logic [COL_W-1:0] chg_col,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             timeout_err,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_n
);
  localparam int COL_B = COL_W / 8;
  localparam int ADR_B = (COL_W + ROW_W) / 8;
  localparam int IW    = $clog2(ADR_B);
  localparam int PW    = $clog2(POLL_MAX + 1);
  localparam int GW    = $clog2(POLL_GAP + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD_RD, ST_ADDR, ST_CMD_GO, ST_WAIT_PIN, ST_CMD_STAT,
    ST_POLL_RD, ST_POLL_GAP, ST_CMD_MODE, ST_DATA_RD, ST_DATA_OUT,
    ST_CMD_CHG, ST_CHG_ADDR, ST_CMD_CHG_GO
  } state_e;

  state_e           st_q, st_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [COL_W-1:0] col_q, col_n;
  logic [LEN_W-1:0] left_q, left_n;
  logic             poll_q, poll_n;
  logic [IW-1:0]    idx_q, idx_n;
  logic [PW-1:0]    polls_q, polls_n;
  logic [GW-1:0]    gap_q, gap_n;
  logic [7:0]       data_q, data_n;
  logic             err_q, err_n;
  logic             fly_q, fly_n;

  logic             eng_start, eng_idle, eng_done;
  cyc_kind_e        eng_kind;
  logic [7:0]       eng_wdata, eng_rdata, addr_byte;
  logic             issuing, rb_arm, rb_ready, chg_take;

  nand_addr_pick #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pick (
    .idx(idx_q), .col(col_q), .row(row_q), .sel_byte(addr_byte)
  );

  nand_rb_watch #(.RB_SETTLE(RB_SETTLE)) u_rbw (
    .clk(clk), .rst_n(rst_n), .arm(rb_arm), .rb_n(nand_rb_n), .ready(rb_ready)
  );

  nand_bus_cycle #(
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW), .RE_HIGH(RE_HIGH)
  ) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .kind(eng_kind),
    .wdata(eng_wdata), .dq_i(nand_dq_i), .idle(eng_idle), .done(eng_done),
    .rdata(eng_rdata), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
  );

  // Cycle request decode per state
  always_comb begin
    issuing   = 1'b1;
    eng_kind  = CYC_CMD;
    eng_wdata = 8'h00;
    case (st_q)
      ST_CMD_RD:     eng_wdata = OP_PAGE_RD;
      ST_ADDR:       begin eng_kind = CYC_ADDR; eng_wdata = addr_byte; end
      ST_CMD_GO:     eng_wdata = OP_PAGE_GO;
      ST_CMD_STAT:   eng_wdata = OP_STATUS;
      ST_POLL_RD:    eng_kind  = CYC_READ;
      ST_CMD_MODE:   eng_wdata = OP_PAGE_RD;
      ST_DATA_RD:    eng_kind  = CYC_READ;
      ST_CMD_CHG:    eng_wdata = OP_COL_SEL;
      ST_CHG_ADDR:   begin eng_kind = CYC_ADDR; eng_wdata = addr_byte; end
      ST_CMD_CHG_GO: eng_wdata = OP_COL_GO;
      default:       issuing = 1'b0;
    endcase
  end

  assign eng_start = issuing && eng_idle && !fly_q;
  assign rb_arm    = (st_q == ST_CMD_GO) && eng_done && !poll_q;
  assign chg_ready = (st_q == ST_DATA_OUT) && out_ready && (left_q != '0);
  assign chg_take  = chg_ready && chg_valid;

  // Next state
  always_comb begin
    st_n    = st_q;
    row_n   = row_q;
    col_n   = col_q;
    left_n  = left_q;
    poll_n  = poll_q;
    idx_n   = idx_q;
    polls_n = polls_q;
    gap_n   = gap_q;
    data_n  = data_q;
    err_n   = err_q;
    fly_n   = fly_q;

    if (eng_start)     fly_n = 1'b1;
    else if (eng_done) fly_n = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_n   = ST_CMD_RD;
          row_n  = req_row;
          col_n  = req_col;
          left_n = req_len;
          poll_n = req_poll;
          err_n  = 1'b0;
        end
      end
      ST_CMD_RD: if (eng_done) begin st_n = ST_ADDR; idx_n = '0; end
      ST_ADDR: begin
        if (eng_done) begin
          if (idx_q == IW'(ADR_B - 1)) st_n = ST_CMD_GO;
          else                         idx_n = idx_q + IW'(1);
        end
      end
      ST_CMD_GO: if (eng_done) st_n = poll_q ? ST_CMD_STAT : ST_WAIT_PIN;
      ST_WAIT_PIN: if (rb_ready) st_n = ST_DATA_RD;
      ST_CMD_STAT: if (eng_done) begin st_n = ST_POLL_RD; polls_n = '0; end
      ST_POLL_RD: begin
        if (eng_done) begin
          if (eng_rdata[STAT_RDY_BIT]) begin
            st_n = ST_CMD_MODE;
          end else if (polls_q == PW'(POLL_MAX - 1)) begin
            st_n  = ST_IDLE;
            err_n = 1'b1;
          end else begin
            polls_n = polls_q + PW'(1);
            gap_n   = GW'(POLL_GAP);
            st_n    = ST_POLL_GAP;
          end
        end
      end
      ST_POLL_GAP: begin
        if (gap_q <= GW'(1)) st_n  = ST_POLL_RD;
        else                 gap_n = gap_q - GW'(1);
      end
      ST_CMD_MODE: if (eng_done) st_n = ST_DATA_RD;
      ST_DATA_RD: begin
        if (eng_done) begin
          st_n   = ST_DATA_OUT;
          data_n = eng_rdata;
        end
      end
      ST_DATA_OUT: begin
        if (out_ready) begin
          if (left_q == '0) begin
            st_n = ST_IDLE;
          end else begin
            left_n = left_q - LEN_W'(1);
            if (chg_take) begin
              col_n = chg_col;
              st_n  = ST_CMD_CHG;
            end else begin
              st_n = ST_DATA_RD;
            end
          end
        end
      end
      ST_CMD_CHG: if (eng_done) begin st_n = ST_CHG_ADDR; idx_n = '0; end
      ST_CHG_ADDR: begin
        if (eng_done) begin
          if (idx_q == IW'(COL_B - 1)) st_n  = ST_CMD_CHG_GO;
          else                         idx_n = idx_q + IW'(1);
        end
      end
      ST_CMD_CHG_GO: if (eng_done) st_n = ST_DATA_RD;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      left_q  <= '0;
      poll_q  <= 1'b0;
      idx_q   <= '0;
      polls_q <= '0;
      gap_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      fly_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      row_q   <= row_n;
      col_q   <= col_n;
      left_q  <= left_n;
      poll_q  <= poll_n;
      idx_q   <= idx_n;
      polls_q <= polls_n;
      gap_q   <= gap_n;
      data_q  <= data_n;
      err_q   <= err_n;
      fly_q   <= fly_n;
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign nand_ce_n   = (st_q == ST_IDLE);
  assign out_valid   = (st_q == ST_DATA_OUT);
  assign out_data    = data_q;
  assign out_last    = out_valid && (left_q == '0);
  assign timeout_err = err_q;

  // R2
  req_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!nand_ce_n && !req_ready));
  // R4
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9
  no_read_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> nand_re_n);
  // R11
  chg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_ready |-> (out_valid && !out_last));
  // R7
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (req_ready && !out_valid));
endmodule

// File: tb/sim_nand_page_reader.sv
module sim_nand_page_reader;
  localparam int WE_LOW   = 2;
  localparam int RE_LOW   = 3;
  localparam int POLL_MAX = 6;
  localparam int BUSY_T   = 40;

  typedef struct packed {
    logic [23:0] row;
    logic [15:0] col;
    logic [15:0] len;
    logic        poll;
    logic        stall;
    logic [7:0]  chg_at;
    logic [15:0] chg_col;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{24'h012345, 16'h0000, 16'd7,  1'b0, 1'b0, 8'hFF, 16'h0000},
    '{24'h0A0B0C, 16'h0123, 16'd11, 1'b1, 1'b1, 8'hFF, 16'h0000},
    '{24'h000001, 16'h07FE, 16'd15, 1'b0, 1'b1, 8'd4,  16'h0020},
    '{24'h123456, 16'h0010, 16'd0,  1'b1, 1'b0, 8'd0,  16'h0400},
    '{24'h00FF00, 16'h0200, 16'd9,  1'b1, 1'b0, 8'd2,  16'h0300},
    '{24'h777777, 16'h0003, 16'd5,  1'b0, 1'b1, 8'd4,  16'h01F0}
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_poll;
  logic [23:0] req_row;
  logic [15:0] req_col, req_len, chg_col;
  logic chg_valid, chg_ready;
  logic out_valid, out_ready, out_last, timeout_err;
  logic [7:0] out_data;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb_n;
  logic [7:0] nand_dq_o, nand_dq_i;

  int n_cmp = 0, n_bad = 0;

  nand_page_reader #(
    .WE_LOW(WE_LOW), .RE_LOW(RE_LOW), .POLL_MAX(POLL_MAX), .POLL_GAP(3)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_poll(req_poll),
    .chg_valid(chg_valid), .chg_ready(chg_ready), .chg_col(chg_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .timeout_err(timeout_err), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] page_byte(input logic [23:0] row, input logic [15:0] col);
    return 8'(row[7:0] + col[7:0] * 8'd7 + col[15:8]);
  endfunction

  // Behavioural target, sampled mid-cycle
  logic        stuck = 1'b0;
  logic        mode_stat = 1'b0;
  logic [15:0] t_col = '0, a_col = '0;
  logic [23:0] a_row = '0, t_row = '0;
  int          a_cnt = 0, busy = 0;
  logic        we_p = 1'b1, re_p = 1'b1;
  logic [8:0]  log_q [64];
  int          log_n = 0, re_cnt = 0;
  int          we_run = 0, re_run = 0, we_bad = 0, re_bad = 0;
  logic        t_rdy;

  assign t_rdy     = (busy == 0) && !stuck;
  assign nand_rb_n = t_rdy;
  assign nand_dq_i = mode_stat ? {1'b1, t_rdy, 6'b0} : page_byte(t_row, t_col);

  always @(negedge clk) begin
    if (busy > 0) busy = busy - 1;
    if (!nand_we_n) we_run = we_run + 1;
    if (!nand_re_n) re_run = re_run + 1;
    if (!we_p && nand_we_n) begin
      if (we_run != WE_LOW) we_bad = we_bad + 1;
      we_run = 0;
    end
    if (!re_p && nand_re_n) begin
      if (re_run != RE_LOW) re_bad = re_bad + 1;
      re_run = 0;
    end
    if (!nand_ce_n) begin
      if (!we_p && nand_we_n) begin
        if (log_n < 64) log_q[log_n] = {nand_cle, nand_dq_o};
        log_n = log_n + 1;
        if (nand_cle) begin
          case (nand_dq_o)
            8'h00: begin mode_stat = 1'b0; a_cnt = 0; end
            8'h30: begin t_col = a_col; t_row = a_row; busy = BUSY_T; end
            8'h70: mode_stat = 1'b1;
            8'h05: a_cnt = 0;
            8'hE0: t_col = a_col;
            default: ;
          endcase
        end else if (nand_ale) begin
          case (a_cnt)
            0: a_col[7:0]   = nand_dq_o;
            1: a_col[15:8]  = nand_dq_o;
            2: a_row[7:0]   = nand_dq_o;
            3: a_row[15:8]  = nand_dq_o;
            4: a_row[23:16] = nand_dq_o;
            default: ;
          endcase
          a_cnt = a_cnt + 1;
        end
      end
      if (!re_p && nand_re_n) begin
        re_cnt = re_cnt + 1;
        if (!mode_stat) t_col = t_col + 16'd1;
      end
    end
    we_p = nand_we_n;
    re_p = nand_re_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [15:0] cur;
    int          got, guard;
    logic        seen_last, take_exp, took, hs;
    logic [8:0]  exp_log [16];
    int          exp_n;
    cur = v.col; got = 0; guard = 0; seen_last = 0; took = 0;
    take_exp = (v.chg_at != 8'hFF) && (16'(v.chg_at) < v.len);
    log_n = 0;
    @(negedge clk);
    req_valid = 1; req_row = v.row; req_col = v.col; req_len = v.len;
    req_poll = v.poll; chg_col = v.chg_col; out_ready = 1;
    @(posedge clk); #1 req_valid = 0;
    chk("R2 ce low after accept", {31'd0, nand_ce_n}, 0);
    chk("R7 error cleared on accept", {31'd0, timeout_err}, 0);
    while (!seen_last && guard < 5000) begin
      @(negedge clk);
      guard++;
      out_ready = v.stall ? ~out_ready : 1'b1;
      if (!took && v.chg_at != 8'hFF && got == int'(v.chg_at)) chg_valid = 1;
      #1;
      hs = out_valid && out_ready;
      if (hs) begin
        chk("R8 data byte", {24'd0, out_data}, {24'd0, page_byte(v.row, cur)});
        chk("R8 last flag", {31'd0, out_last}, {31'd0, (got == int'(v.len))});
        seen_last = out_last;
        cur = cur + 16'd1;
        if (chg_valid && chg_ready) begin took = 1; cur = v.chg_col; end
        got++;
      end
      @(posedge clk); #1;
      if (took || seen_last) chg_valid = 0;
    end
    chg_valid = 0;
    chk("R8 byte count", got, 32'(v.len) + 1);
    chk("R11 column change taken only before last", {31'd0, took}, {31'd0, take_exp});
    repeat (3) @(negedge clk);
    chk("R2 idle after last", {31'd0, req_ready}, 1);
    exp_n = 0;
    exp_log[exp_n++] = {1'b1, 8'h00};
    exp_log[exp_n++] = {1'b0, v.col[7:0]};
    exp_log[exp_n++] = {1'b0, v.col[15:8]};
    exp_log[exp_n++] = {1'b0, v.row[7:0]};
    exp_log[exp_n++] = {1'b0, v.row[15:8]};
    exp_log[exp_n++] = {1'b0, v.row[23:16]};
    exp_log[exp_n++] = {1'b1, 8'h30};
    if (v.poll) begin
      exp_log[exp_n++] = {1'b1, 8'h70};
      exp_log[exp_n++] = {1'b1, 8'h00};
    end
    if (take_exp) begin
      exp_log[exp_n++] = {1'b1, 8'h05};
      exp_log[exp_n++] = {1'b0, v.chg_col[7:0]};
      exp_log[exp_n++] = {1'b0, v.chg_col[15:8]};
      exp_log[exp_n++] = {1'b1, 8'hE0};
    end
    chk("R3 R6 R10 latched cycle count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk("R3 R6 R10 latched cycle", {23'd0, log_q[i]}, {23'd0, exp_log[i]});
  endtask

  initial begin
    req_valid = 0; req_row = '0; req_col = '0; req_len = '0; req_poll = 0;
    chg_valid = 0; chg_col = '0; out_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 ce_n in reset", {31'd0, nand_ce_n}, 1);
    chk("R1 we_n in reset", {31'd0, nand_we_n}, 1);
    chk("R1 re_n in reset", {31'd0, nand_re_n}, 1);
    chk("R1 strobes and driver in reset", {29'd0, nand_cle, nand_ale, nand_dq_oe}, 0);
    chk("R1 out_valid and error in reset", {30'd0, out_valid, timeout_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 req_ready after reset", {31'd0, req_ready}, 1);

    // R11: column change offered while idle is not taken and leaves the bus idle
    chg_valid = 1; chg_col = 16'h0555;
    repeat (4) @(negedge clk);
    chk("R11 chg_ready while idle", {31'd0, chg_ready}, 0);
    chk("R11 bus untouched while idle", {29'd0, nand_ce_n, nand_we_n, nand_re_n}, 7);
    chg_valid = 0;

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R7: target never ready in poll mode
    stuck = 1; re_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_row = 24'h00ABCD; req_col = 16'h0040; req_len = 16'd3; req_poll = 1;
    @(posedge clk); #1 req_valid = 0;
    begin
      int g;
      logic any_out;
      g = 0; any_out = 0;
      while (!(req_ready && timeout_err) && g < 2000) begin
        @(negedge clk); g++;
        if (out_valid) any_out = 1;
      end
      chk("R7 timeout flag", {31'd0, timeout_err}, 1);
      chk("R7 no data on timeout", {31'd0, any_out}, 0);
      chk("R7 status reads before timeout", re_cnt, POLL_MAX);
      chk("R7 deselected after timeout", {31'd0, nand_ce_n}, 1);
    end
    stuck = 0;
    busy = 0;
    run_vec(VECS[0]);

    chk("R4 write pulse width", we_bad, 0);
    chk("R8 read pulse width", re_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule